// File: doc/BRIEF.md
# Muller C-Element Token Pipeline

This block is a clocked model of an elastic pipeline whose control is a chain of C-elements, one per stage, each paired with a data register. A stage has no global shift enable. It moves only when its two neighbours agree: it copies the state of the stage on its left when the stage on its right holds the opposite value, and otherwise keeps its own state. Tokens, meaning the data words, ripple towards the consumer, and bubbles ripple back towards the producer. A stalled consumer therefore fills the chain from the right, one stage after another, until the producer is refused.

The left end takes a four-phase request/acknowledge handshake from a producer. The word on `in_data` must be valid while `in_req` is high. The right end offers a four-phase handshake to a consumer, which may hold off its acknowledge for as long as it likes. Two views of the chain are brought out for observation: a per-stage map of which stages are occupied (a token or a return-to-zero phase) and which are bubbles, and the number of distinct data words currently held.

Top module: `muller_token_pipe`

## Requirements
- R1: While `rst_n` is low, every stage state and data register is 0. So `in_ack`, `out_req`, `out_data`, `stage_full` and `word_cnt` all read 0.
- R2: At each clock edge a stage takes its left input's value when its right input holds the opposite value, and otherwise keeps its state (next = a·b + z·(a+b), with a = left and b = inverted right). Stage 0's left input is `in_req`. The last stage's right input is `out_ack`. `in_ack` is stage 0's state and `out_req` is the last stage's state.
- R3: In an empty pipe, `in_ack` rises at the first clock edge after `in_req` rises. `out_req` rises at the STAGES-th edge, with `out_data` equal to the word offered.
- R4: Words reach the consumer in the order they were accepted, with none lost and none duplicated, under any mix of producer and consumer stalls.
- R5: A stage's data register loads its left neighbour's word only at a 0-to-1 transition of its state. `out_data` holds its value for as long as `out_req` stays high.
- R6: `word_cnt` equals the number of rising `in_ack` edges minus the number of rising `out_ack` edges since reset. It counts the stages whose state is 1 while their right input is 0.
- R7: If `out_ack` stays low, the pipe holds at most ceil(STAGES/2) words and then refuses the producer: `in_ack` stays low while `in_req` is high. With STAGES = 4 the stall holds 2 words, and `stage_full` reads 4'b1111.
- R8: `stage_full[i]` is 1 when stage i's state differs from its right input (bit 0 is the stage next to the producer). After the pipe drains, with both handshakes idle, `stage_full` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_req | input | 1 | Producer four-phase request |
| in_data | input | WIDTH | Producer word, valid while in_req is high |
| in_ack | output | 1 | Acknowledge to producer (stage 0 state) |
| out_req | output | 1 | Request to consumer (last stage state) |
| out_data | output | WIDTH | Word held by the last stage |
| out_ack | input | 1 | Consumer four-phase acknowledge |
| stage_full | output | STAGES | Per-stage occupied (1) or bubble (0) map |
| word_cnt | output | $clog2(STAGES+1) | Distinct data words held |

## Verification
Each stage state is registered, so a handshake edge moves one stage per clock. `in_ack` answers `in_req` at the next edge, and an empty pipe raises `out_req` STAGES edges after the request. The bench drives inputs on the falling edge and samples a quarter period after the rising edge. The latency checks count rising edges exactly from the falling edge on which the request was raised. `word_cnt` is combinational from the stage states and `out_ack`, so it is compared after every rising edge against a bench count of rising `in_ack` and `out_ack` edges. The stall state is checked only after enough idle cycles for any ripple to settle.

// File: rtl/muller_pipe_pkg.sv
package muller_pipe_pkg;

  // Two-input C-element: output follows the inputs when they agree,
  // otherwise it keeps its previous value.
  function automatic logic celem_next(input logic a, input logic b, input logic z);
    return (a & b) | (z & (a | b));
  endfunction

  // A stage is occupied when its state differs from the value on its right.
  function automatic logic stage_busy(input logic self_c, input logic right_c);
    return self_c ^ right_c;
  endfunction

  // A stage carries the leading edge of a data word when it is 1 and its
  // right side is 0.
  function automatic logic stage_word(input logic self_c, input logic right_c);
    return self_c & ~right_c;
  endfunction

  // Largest number of distinct words a chain of n stages can hold.
  function automatic int max_words(input int n);
    return (n + 1) / 2;
  endfunction

endpackage

// File: rtl/muller_pipe_stage.sv
module muller_pipe_stage
  import muller_pipe_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             left_c,
  input  logic             right_c,
  input  logic [WIDTH-1:0] left_d,
  output logic             c_q,
  output logic [WIDTH-1:0] d_q,
  output logic             cap_evt
);

  logic c_nxt;

  // Take the left value only when the right side holds its opposite.
  assign c_nxt   = celem_next(left_c, ~right_c, c_q);
  assign cap_evt = c_nxt & ~c_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_q <= 1'b0;
      d_q <= '0;
    end else begin
      c_q <= c_nxt;
      if (cap_evt) begin
        d_q <= left_d;
      end
    end
  end

endmodule

// File: rtl/muller_pipe_occupancy.sv
module muller_pipe_occupancy
  import muller_pipe_pkg::*;
#(
  parameter int STAGES = 4,
  parameter int CNT_W  = 3
) (
  input  logic [STAGES-1:0] st,
  input  logic [STAGES-1:0] rgt,
  output logic [STAGES-1:0] full_map,
  output logic [CNT_W-1:0]  word_cnt
);

  logic [STAGES-1:0] word_map;

  for (genvar i = 0; i < STAGES; i++) begin : g_map
    assign full_map[i] = stage_busy(st[i], rgt[i]);
    assign word_map[i] = stage_word(st[i], rgt[i]);
  end

  always_comb begin
    word_cnt = '0;
    for (int i = 0; i < STAGES; i++) begin
      word_cnt = word_cnt + CNT_W'(word_map[i]);
    end
  end

endmodule

// File: rtl/muller_token_pipe.sv
module muller_token_pipe
  import muller_pipe_pkg::*;
#(
  parameter  int STAGES = 4,
  parameter  int WIDTH  = 8,
  localparam int CNT_W  = $clog2(STAGES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_req,
  input  logic [WIDTH-1:0]  in_data,
  output logic              in_ack,
  output logic              out_req,
  output logic [WIDTH-1:0]  out_data,
  input  logic              out_ack,
  output logic [STAGES-1:0] stage_full,
  output logic [CNT_W-1:0]  word_cnt
);

  // Named internal nets, shared with the bound checker.
  logic [STAGES-1:0] st_q;
  logic [STAGES-1:0] lft_c;
  logic [STAGES-1:0] rgt_c;
  logic [STAGES-1:0] cap_evt;
  logic [WIDTH-1:0]  dq    [STAGES];
  logic [WIDTH-1:0]  lft_d [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign lft_c[i] = in_req;
      assign lft_d[i] = in_data;
    end else begin : g_body
      assign lft_c[i] = st_q[i-1];
      assign lft_d[i] = dq[i-1];
    end

    if (i == STAGES - 1) begin : g_tail
      assign rgt_c[i] = out_ack;
    end else begin : g_inner
      assign rgt_c[i] = st_q[i+1];
    end

    muller_pipe_stage #(
      .WIDTH(WIDTH)
    ) i_stage (
      .clk    (clk),
      .rst_n  (rst_n),
      .left_c (lft_c[i]),
      .right_c(rgt_c[i]),
      .left_d (lft_d[i]),
      .c_q    (st_q[i]),
      .d_q    (dq[i]),
      .cap_evt(cap_evt[i])
    );
  end

  muller_pipe_occupancy #(
    .STAGES(STAGES),
    .CNT_W (CNT_W)
  ) i_occ (
    .st      (st_q),
    .rgt     (rgt_c),
    .full_map(stage_full),
    .word_cnt(word_cnt)
  );

  assign in_ack   = st_q[0];
  assign out_req  = st_q[STAGES-1];
  assign out_data = dq[STAGES-1];

endmodule

// File: rtl/muller_pipe_checks.sv
module muller_pipe_checks
  import muller_pipe_pkg::*;
#(
  parameter int STAGES = 4,
  parameter int WIDTH  = 8,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_req,
  input logic              in_ack,
  input logic              out_req,
  input logic              out_ack,
  input logic [WIDTH-1:0]  out_data,
  input logic [CNT_W-1:0]  word_cnt,
  input logic [STAGES-1:0] st,
  input logic [STAGES-1:0] lft,
  input logic [STAGES-1:0] rgt
);

  for (genvar i = 0; i < STAGES; i++) begin : g_chk
    // R2: left and right disagree -> stage adopts the left value next edge
    a_r2_celem_take: assert property (@(posedge clk) disable iff (!rst_n)
      (lft[i] != rgt[i]) |=> (st[i] == $past(lft[i])));
    // R2: left and right agree -> stage keeps its state
    a_r2_celem_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (lft[i] == rgt[i]) |=> $stable(st[i]));
  end

  // R5: word offered to the consumer does not move while out_req stays high
  a_r5_out_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_req && $past(out_req)) |-> $stable(out_data));

  // R6: words held change only by producer accepts and consumer takes
  a_r6_word_balance: assert property (@(posedge clk) disable iff (!rst_n)
    int'(word_cnt) == int'($past(word_cnt)) + int'($rose(in_ack)) - int'($rose(out_ack)));

  // R7: never more than ceil(STAGES/2) distinct words
  a_r7_word_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(word_cnt) <= max_words(STAGES));

  // R3: producer side responds only to its own request level
  a_r3_ack_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ack) |-> $past(in_req));

endmodule

bind muller_token_pipe muller_pipe_checks #(
  .STAGES(STAGES),
  .WIDTH (WIDTH),
  .CNT_W (CNT_W)
) i_checks (
  .clk     (clk),
  .rst_n   (rst_n),
  .in_req  (in_req),
  .in_ack  (in_ack),
  .out_req (out_req),
  .out_ack (out_ack),
  .out_data(out_data),
  .word_cnt(word_cnt),
  .st      (st_q),
  .lft     (lft_c),
  .rgt     (rgt_c)
);

// File: tb/test_muller_token_pipe.sv
module test_muller_token_pipe;

  localparam int S  = 4;
  localparam int W  = 8;
  localparam int CW = $clog2(S + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_req = 1'b0;
  logic [W-1:0]  in_data = '0;
  logic          in_ack;
  logic          out_req;
  logic [W-1:0]  out_data;
  logic          out_ack = 1'b0;
  logic [S-1:0]  stage_full;
  logic [CW-1:0] word_cnt;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] exp_q[$];
  int  sent = 0;
  int  rcvd = 0;
  bit  cons_en = 1'b0;
  int  cstall_max = 0;
  int  pstall_max = 0;
  bit  third_done = 1'b0;
  int  exp_cnt = 0;

  always #10 clk = ~clk;  // 50 MHz

  muller_token_pipe #(.STAGES(S), .WIDTH(W)) i_muller_token_pipe (
    .clk(clk), .rst_n(rst_n), .in_req(in_req), .in_data(in_data),
    .in_ack(in_ack), .out_req(out_req), .out_data(out_data),
    .out_ack(out_ack), .stage_full(stage_full), .word_cnt(word_cnt)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Producer driver: full four-phase cycle, expected word queued at request.
  task automatic send(input logic [W-1:0] w);
    repeat ($urandom_range(0, pstall_max)) @(negedge clk);
    in_data = w;
    exp_q.push_back(w);
    sent++;
    in_req = 1'b1;
    do @(negedge clk); while (!in_ack);
    in_req = 1'b0;
    do @(negedge clk); while (in_ack);
  endtask

  // Consumer monitor: pops and compares each offered word (R4, R5).
  initial begin
    forever begin
      @(negedge clk);
      if (cons_en && out_req && !out_ack) begin
        repeat ($urandom_range(0, cstall_max)) @(negedge clk);
        if (exp_q.size() == 0) begin
          check(1'b0, "R4 unexpected word", int'(out_data), -1);
        end else begin
          logic [W-1:0] e;
          e = exp_q.pop_front();
          check(out_data == e, "R4 order", int'(out_data), int'(e));
        end
        rcvd++;
        out_ack = 1'b1;
        do @(negedge clk); while (out_req);
        out_ack = 1'b0;
      end
    end
  end

  // Word count monitor (R6), sampled a quarter period after the rising edge.
  initial begin
    logic p_in;
    logic p_out;
    p_in = 1'b0;
    p_out = 1'b0;
    forever begin
      @(posedge clk);
      #5;
      if (!rst_n) begin
        exp_cnt = 0;
        p_in = 1'b0;
        p_out = 1'b0;
      end else begin
        if (in_ack && !p_in) exp_cnt++;
        if (out_ack && !p_out) exp_cnt--;
        p_in = in_ack;
        p_out = out_ack;
        check(int'(word_cnt) == exp_cnt, "R6 word_cnt", int'(word_cnt), exp_cnt);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    finish_sim();
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #5;
    check(in_ack == 1'b0, "R1 in_ack", int'(in_ack), 0);
    check(out_req == 1'b0, "R1 out_req", int'(out_req), 0);
    check(out_data == '0, "R1 out_data", int'(out_data), 0);
    check(stage_full == '0, "R1 stage_full", int'(stage_full), 0);
    check(word_cnt == '0, "R1 word_cnt", int'(word_cnt), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 / R2: empty-pipe latency, consumer idle
    in_data = 8'hA5;
    exp_q.push_back(8'hA5);
    sent++;
    in_req = 1'b1;
    @(posedge clk);
    #5;
    check(in_ack == 1'b1, "R2 R3 in_ack after one edge", int'(in_ack), 1);
    repeat (S - 2) @(posedge clk);
    #5;
    check(out_req == 1'b0, "R3 out_req early", int'(out_req), 0);
    @(posedge clk);
    #5;
    check(out_req == 1'b1, "R3 out_req at STAGES edges", int'(out_req), 1);
    check(out_data == 8'hA5, "R3 out_data", int'(out_data), 'hA5);
    @(negedge clk);
    in_req = 1'b0;
    do @(negedge clk); while (in_ack);
    cons_en = 1'b1;
    wait (exp_q.size() == 0);
    repeat (2 * S + 4) @(negedge clk);

    // R8: drained pipe is all bubbles
    check(stage_full == '0, "R8 drained stage_full", int'(stage_full), 0);
    check(word_cnt == '0, "R6 drained word_cnt", int'(word_cnt), 0);

    // R7: stalled consumer, pipe fills and refuses the producer
    cons_en = 1'b0;
    send(8'h11);
    send(8'h22);
    fork
      begin
        send(8'h33);
        third_done = 1'b1;
      end
    join_none
    repeat (4 * S + 10) @(negedge clk);
    check(in_req == 1'b1 && in_ack == 1'b0, "R7 producer refused", int'(in_ack), 0);
    check(int'(word_cnt) == (S + 1) / 2, "R7 words held", int'(word_cnt), (S + 1) / 2);
    check(stage_full == 4'b1111, "R7 R8 stage_full when full", int'(stage_full), 'hF);
    check(out_req == 1'b1, "R7 out_req offered", int'(out_req), 1);
    check(out_data == 8'h11, "R5 head word held during stall", int'(out_data), 'h11);
    cons_en = 1'b1;
    wait (third_done);
    wait (exp_q.size() == 0);
    repeat (2 * S + 4) @(negedge clk);
    check(stage_full == '0, "R8 stage_full after stall drain", int'(stage_full), 0);

    // R4: back-to-back words, no stalls
    pstall_max = 0;
    cstall_max = 0;
    for (int k = 0; k < 24; k++) send(W'(k * 7 + 3));
    wait (exp_q.size() == 0);

    // R4: random producer and consumer stalls
    pstall_max = 3;
    cstall_max = 5;
    for (int k = 0; k < 60; k++) send(W'($urandom));
    wait (exp_q.size() == 0);

    // R4: slow consumer, fast producer
    pstall_max = 0;
    cstall_max = 9;
    for (int k = 0; k < 30; k++) send(W'(8'hF0 ^ k));
    wait (exp_q.size() == 0);
    repeat (2 * S + 4) @(negedge clk);

    check(rcvd == sent, "R4 words delivered", rcvd, sent);
    check(stage_full == '0, "R8 final stage_full", int'(stage_full), 0);
    check(word_cnt == '0, "R6 final word_cnt", int'(word_cnt), 0);
    finish_sim();
  end

endmodule